// File: doc/BRIEF.md
# Strap Latch and Frequency Source Selector

This block sits in the digital control section of a clock synthesizer. When power-good rises for the first time after reset, it captures the five frequency-select straps and the output-current-mode strap. From then on it treats a shared multifunction pin as an active-low power-down request. The captured straps are also returned as status.

Every cycle it works out which frequency source is in force: the captured hardware code, a code written by software, or the direct M/N programming of the VCO, where VCO = 14.318 MHz × (N+4)/M. A level from the watchdog overrides that choice. While the watchdog level is high, M/N mode is dropped and the code becomes either the hardware code or a separately held safe code. The block also turns a 3-bit ratio field into the VCO-to-CPU, VCO-to-3V66 and VCO-to-PCI divide values. In the fixed 3V66/PCI mode it produces the two fixed target frequencies.

Register contents arrive on input ports. Every output is registered, so a change on any source appears at the outputs exactly one clock later as a single clean step.

Top module: `freq_sel_top`

## Requirements
- R1: While reset is held, and afterwards until power-good first rises, the captured frequency straps, the captured current strap, `strap_done`, `pwr_dn`, `freq_code`, `mn_mode`, `n_out` and `m_out` are all zero.
- R2: The straps are captured on the clock edge that first sees `pwr_good` high after a low cycle, and `strap_done` rises on that same edge. Later strap changes and later rises of `pwr_good` leave the captured values unchanged.
- R3: `pwr_dn` is 0 until the straps have been captured. After capture, `pwr_dn` is the inverse of `mf_pin`, delayed by one clock.
- R4: With `wdt_expired` low, `freq_code` equals the captured straps when `sw_sel_en` is 0 and equals `sw_code` when `sw_sel_en` is 1. It updates one clock after its source changes.
- R5: With `wdt_expired` low and `mn_en` 1, the block sets `mn_mode` to 1 and passes `n_div` (9 bits) and `m_div` (5 bits) to `n_out` and `m_out` one clock later. When M/N mode is not in force, `mn_mode`, `n_out` and `m_out` are 0.
- R6: While `wdt_expired` is high, `mn_mode` is 0 and `freq_code` ignores `sw_sel_en`. It is the captured straps when `safe_en` is 0 and `safe_code` when `safe_en` is 1.
- R7: Each `ratio_sel` value gives CPU/3V66/PCI divide values one clock later: 0 and 1 give 2/6/12, 2 gives 3/6/12, 3 gives 4/10/20, 4 and 5 give 6/5/10, and 6 and 7 give 3/5/10.
- R8: With `fix_en` 1, `fix_mode` is 1 and `fix_agp`/`fix_pci`, in units of 100 kHz, are chosen by `fix_sel`: 0 gives 720/360, 1 gives 640/320, 2 gives 768/384 and 3 gives 672/336. PCI is always half of 3V66. With `fix_en` 0, all three outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pwr_good | input | 1 | Power-good level, active high, synchronous to clk |
| fs_strap | input | 5 | Frequency-select strap inputs |
| cur_strap | input | 1 | Output-current-mode strap |
| mf_pin | input | 1 | Multifunction pin; active-low power-down after capture |
| sw_sel_en | input | 1 | Select the software frequency code |
| sw_code | input | 5 | Software frequency code |
| mn_en | input | 1 | Enable M/N programming |
| n_div | input | 9 | N value for the VCO equation |
| m_div | input | 5 | M value for the VCO equation |
| wdt_expired | input | 1 | Watchdog expired level |
| safe_en | input | 1 | Use the safe code when the watchdog has expired |
| safe_code | input | 5 | Safe frequency code |
| ratio_sel | input | 3 | Divide ratio select |
| fix_en | input | 1 | Fixed 3V66/PCI mode enable |
| fix_sel | input | 2 | Fixed frequency select |
| freq_code | output | 5 | Active frequency table code |
| mn_mode | output | 1 | M/N programming in force |
| n_out | output | 9 | N value in force (0 outside M/N mode) |
| m_out | output | 5 | M value in force (0 outside M/N mode) |
| cpu_div | output | 3 | VCO/CPU divide value |
| agp_div | output | 4 | VCO/3V66 divide value |
| pci_div | output | 5 | VCO/PCI divide value |
| fix_mode | output | 1 | Fixed mode active |
| fix_agp | output | 10 | Fixed 3V66 frequency, 100 kHz units |
| fix_pci | output | 10 | Fixed PCI frequency, 100 kHz units |
| lat_fs | output | 5 | Captured frequency straps (status) |
| lat_cur | output | 1 | Captured current strap (status) |
| strap_done | output | 1 | Straps have been captured |
| pwr_dn | output | 1 | Power-down request, active high |

## Verification
The assertions check these invariants on every cycle:
- the captured straps never move once captured;
- power-down stays low before capture;
- the code follows its selected source one clock later;
- the watchdog level always drops M/N mode;
- PCI divide and fixed PCI frequency are always exactly twice or half their 3V66 partners.

Only the bench scenarios can show the rest. These cover capture happening on the first power-good rise and never on a second one, the exact divide and fixed-frequency values for each select code, and the safe-code versus hardware-code choice under the watchdog override.

// File: rtl/freq_sel_pkg.sv
package freq_sel_pkg;

  localparam int CPU_DW = 3;
  localparam int AGP_DW = 4;
  localparam int PCI_DW = 5;
  localparam int FIX_W  = 10;

  typedef struct packed {
    logic [CPU_DW-1:0] cpu;
    logic [AGP_DW-1:0] agp;
    logic [PCI_DW-1:0] pci;
  } ratio_t;

  // VCO divide values for each ratio select code
  function automatic ratio_t ratio_lookup(input logic [2:0] sel);
    ratio_t r;
    unique case (sel)
      3'd0, 3'd1: r = '{cpu: 3'd2, agp: 4'd6,  pci: 5'd12};
      3'd2:       r = '{cpu: 3'd3, agp: 4'd6,  pci: 5'd12};
      3'd3:       r = '{cpu: 3'd4, agp: 4'd10, pci: 5'd20};
      3'd4, 3'd5: r = '{cpu: 3'd6, agp: 4'd5,  pci: 5'd10};
      default:    r = '{cpu: 3'd3, agp: 4'd5,  pci: 5'd10};
    endcase
    return r;
  endfunction

  // Fixed-mode 3V66 frequency in 100 kHz units; PCI is half of it
  function automatic logic [FIX_W-1:0] fix_agp_lookup(input logic [1:0] sel);
    logic [FIX_W-1:0] f;
    unique case (sel)
      2'd0:    f = 10'd720;
      2'd1:    f = 10'd640;
      2'd2:    f = 10'd768;
      default: f = 10'd672;
    endcase
    return f;
  endfunction

endpackage

// File: rtl/strap_latch.sv
module strap_latch #(
  parameter int FS_W = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            pwr_good,
  input  logic [FS_W-1:0] fs_strap,
  input  logic            cur_strap,
  input  logic            mf_pin,
  output logic [FS_W-1:0] lat_fs,
  output logic            lat_cur,
  output logic            strap_done,
  output logic            pwr_dn
);

  logic pg_q;
  logic pg_rise;
  logic capture;

  assign pg_rise = pwr_good & ~pg_q;
  assign capture = pg_rise & ~strap_done;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pg_q       <= 1'b0;
      lat_fs     <= '0;
      lat_cur    <= 1'b0;
      strap_done <= 1'b0;
      pwr_dn     <= 1'b0;
    end else begin
      pg_q   <= pwr_good;
      pwr_dn <= strap_done & ~mf_pin;
      if (capture) begin
        lat_fs     <= fs_strap;
        lat_cur    <= cur_strap;
        strap_done <= 1'b1;
      end
    end
  end

  // R2
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strap_done && $past(strap_done)) |-> ($stable(lat_fs) && $stable(lat_cur)));

  // R3
  pd_before_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(strap_done) |-> !pwr_dn);

  // R2
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strap_done |=> strap_done);

endmodule

// File: rtl/freq_src_mux.sv
module freq_src_mux #(
  parameter int FS_W = 5,
  parameter int N_W  = 9,
  parameter int M_W  = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [FS_W-1:0] lat_fs,
  input  logic            sw_sel_en,
  input  logic [FS_W-1:0] sw_code,
  input  logic            mn_en,
  input  logic [N_W-1:0]  n_div,
  input  logic [M_W-1:0]  m_div,
  input  logic            wdt_expired,
  input  logic            safe_en,
  input  logic [FS_W-1:0] safe_code,
  output logic [FS_W-1:0] freq_code,
  output logic            mn_mode,
  output logic [N_W-1:0]  n_out,
  output logic [M_W-1:0]  m_out
);

  logic [FS_W-1:0] normal_code;
  logic [FS_W-1:0] override_code;
  logic [FS_W-1:0] next_code;
  logic            mn_active;

  assign normal_code   = sw_sel_en ? sw_code : lat_fs;
  assign override_code = safe_en ? safe_code : lat_fs;
  assign next_code     = wdt_expired ? override_code : normal_code;
  assign mn_active     = mn_en & ~wdt_expired;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      freq_code <= '0;
      mn_mode   <= 1'b0;
      n_out     <= '0;
      m_out     <= '0;
    end else begin
      freq_code <= next_code;
      mn_mode   <= mn_active;
      n_out     <= mn_active ? n_div : '0;
      m_out     <= mn_active ? m_div : '0;
    end
  end

  // R4
  hw_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!wdt_expired && !sw_sel_en) |-> (freq_code == $past(lat_fs)));

  // R6
  wdt_drops_mn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_expired |=> !mn_mode);

  // R5
  mn_idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mn_mode |-> (n_out == '0 && m_out == '0));

endmodule

// File: rtl/divider_select.sv
module divider_select
  import freq_sel_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        ratio_sel,
  input  logic              fix_en,
  input  logic [1:0]        fix_sel,
  output logic [CPU_DW-1:0] cpu_div,
  output logic [AGP_DW-1:0] agp_div,
  output logic [PCI_DW-1:0] pci_div,
  output logic              fix_mode,
  output logic [FIX_W-1:0]  fix_agp,
  output logic [FIX_W-1:0]  fix_pci
);

  ratio_t           ratio_next;
  logic [FIX_W-1:0] agp_next;

  assign ratio_next = ratio_lookup(ratio_sel);
  assign agp_next   = fix_en ? fix_agp_lookup(fix_sel) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cpu_div  <= '0;
      agp_div  <= '0;
      pci_div  <= '0;
      fix_mode <= 1'b0;
      fix_agp  <= '0;
      fix_pci  <= '0;
    end else begin
      cpu_div  <= ratio_next.cpu;
      agp_div  <= ratio_next.agp;
      pci_div  <= ratio_next.pci;
      fix_mode <= fix_en;
      fix_agp  <= agp_next;
      fix_pci  <= agp_next >> 1;
    end
  end

  // R7
  pci_twice_agp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, pci_div} == {agp_div, 1'b0}));

  // R8
  fix_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, fix_agp} == {fix_pci, 1'b0}));

  // R8
  fix_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fix_mode |-> (fix_agp == '0));

endmodule

// File: rtl/freq_sel_top.sv
module freq_sel_top
  import freq_sel_pkg::*;
#(
  parameter int FS_W = 5,
  parameter int N_W  = 9,
  parameter int M_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr_good,
  input  logic [FS_W-1:0]   fs_strap,
  input  logic              cur_strap,
  input  logic              mf_pin,
  input  logic              sw_sel_en,
  input  logic [FS_W-1:0]   sw_code,
  input  logic              mn_en,
  input  logic [N_W-1:0]    n_div,
  input  logic [M_W-1:0]    m_div,
  input  logic              wdt_expired,
  input  logic              safe_en,
  input  logic [FS_W-1:0]   safe_code,
  input  logic [2:0]        ratio_sel,
  input  logic              fix_en,
  input  logic [1:0]        fix_sel,
  output logic [FS_W-1:0]   freq_code,
  output logic              mn_mode,
  output logic [N_W-1:0]    n_out,
  output logic [M_W-1:0]    m_out,
  output logic [CPU_DW-1:0] cpu_div,
  output logic [AGP_DW-1:0] agp_div,
  output logic [PCI_DW-1:0] pci_div,
  output logic              fix_mode,
  output logic [FIX_W-1:0]  fix_agp,
  output logic [FIX_W-1:0]  fix_pci,
  output logic [FS_W-1:0]   lat_fs,
  output logic              lat_cur,
  output logic              strap_done,
  output logic              pwr_dn
);

  strap_latch #(.FS_W(FS_W)) u_latch (
    .clk        (clk),
    .rst_n      (rst_n),
    .pwr_good   (pwr_good),
    .fs_strap   (fs_strap),
    .cur_strap  (cur_strap),
    .mf_pin     (mf_pin),
    .lat_fs     (lat_fs),
    .lat_cur    (lat_cur),
    .strap_done (strap_done),
    .pwr_dn     (pwr_dn)
  );

  freq_src_mux #(.FS_W(FS_W), .N_W(N_W), .M_W(M_W)) u_mux (
    .clk         (clk),
    .rst_n       (rst_n),
    .lat_fs      (lat_fs),
    .sw_sel_en   (sw_sel_en),
    .sw_code     (sw_code),
    .mn_en       (mn_en),
    .n_div       (n_div),
    .m_div       (m_div),
    .wdt_expired (wdt_expired),
    .safe_en     (safe_en),
    .safe_code   (safe_code),
    .freq_code   (freq_code),
    .mn_mode     (mn_mode),
    .n_out       (n_out),
    .m_out       (m_out)
  );

  divider_select u_div (
    .clk       (clk),
    .rst_n     (rst_n),
    .ratio_sel (ratio_sel),
    .fix_en    (fix_en),
    .fix_sel   (fix_sel),
    .cpu_div   (cpu_div),
    .agp_div   (agp_div),
    .pci_div   (pci_div),
    .fix_mode  (fix_mode),
    .fix_agp   (fix_agp),
    .fix_pci   (fix_pci)
  );

  // R1
  idle_before_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !strap_done |-> (lat_fs == '0 && !lat_cur && !pwr_dn));

endmodule

// File: tb/freq_sel_top_tb.sv
module freq_sel_top_tb;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwr_good = 1'b0;
  logic [4:0] fs_strap = 5'h0B;
  logic cur_strap = 1'b1;
  logic mf_pin = 1'b1;
  logic sw_sel_en = 1'b0;
  logic [4:0] sw_code = 5'h00;
  logic mn_en = 1'b0;
  logic [8:0] n_div = 9'h000;
  logic [4:0] m_div = 5'h00;
  logic wdt_expired = 1'b0;
  logic safe_en = 1'b0;
  logic [4:0] safe_code = 5'h00;
  logic [2:0] ratio_sel = 3'd0;
  logic fix_en = 1'b0;
  logic [1:0] fix_sel = 2'd0;

  logic [4:0] freq_code;
  logic mn_mode;
  logic [8:0] n_out;
  logic [4:0] m_out;
  logic [2:0] cpu_div;
  logic [3:0] agp_div;
  logic [4:0] pci_div;
  logic fix_mode;
  logic [9:0] fix_agp, fix_pci;
  logic [4:0] lat_fs;
  logic lat_cur, strap_done, pwr_dn;

  always #4 clk = ~clk;

  freq_sel_top u_dut (
    .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .fs_strap(fs_strap),
    .cur_strap(cur_strap), .mf_pin(mf_pin), .sw_sel_en(sw_sel_en),
    .sw_code(sw_code), .mn_en(mn_en), .n_div(n_div), .m_div(m_div),
    .wdt_expired(wdt_expired), .safe_en(safe_en), .safe_code(safe_code),
    .ratio_sel(ratio_sel), .fix_en(fix_en), .fix_sel(fix_sel),
    .freq_code(freq_code), .mn_mode(mn_mode), .n_out(n_out), .m_out(m_out),
    .cpu_div(cpu_div), .agp_div(agp_div), .pci_div(pci_div),
    .fix_mode(fix_mode), .fix_agp(fix_agp), .fix_pci(fix_pci),
    .lat_fs(lat_fs), .lat_cur(lat_cur), .strap_done(strap_done), .pwr_dn(pwr_dn)
  );

  typedef struct packed {
    logic [4:0] fc; logic mn; logic [8:0] n; logic [4:0] m;
    logic [2:0] cpu; logic [3:0] agp; logic [4:0] pci;
    logic fx; logic [9:0] fa; logic [9:0] fp;
    logic [4:0] lfs; logic lcur; logic dn; logic pd;
  } obs_t;

  obs_t  exp_q[$];
  string tag_q[$];
  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  // independent reference state
  logic       m_pg = 1'b0, m_done = 1'b0, m_cur = 1'b0;
  logic [4:0] m_lat = 5'h00;

  int cpu_tab[8] = '{2, 2, 3, 4, 6, 6, 3, 3};
  int agp_tab[8] = '{6, 6, 6, 10, 5, 5, 5, 5};
  int fix_tab[4] = '{720, 640, 768, 672};

  function automatic obs_t sample_dut();
    obs_t o;
    o = '{fc: freq_code, mn: mn_mode, n: n_out, m: m_out, cpu: cpu_div,
          agp: agp_div, pci: pci_div, fx: fix_mode, fa: fix_agp, fp: fix_pci,
          lfs: lat_fs, lcur: lat_cur, dn: strap_done, pd: pwr_dn};
    return o;
  endfunction

  task automatic check(input string tag, input obs_t act, input obs_t exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // driver: predicts the outputs after the coming edge and pushes them
  task automatic step(input string tag);
    obs_t e;
    logic cap, wd_mn;
    cap   = pwr_good && !m_pg && !m_done;
    wd_mn = mn_en && !wdt_expired;
    e.fc  = wdt_expired ? (safe_en ? safe_code : m_lat) : (sw_sel_en ? sw_code : m_lat);
    e.mn  = wd_mn;
    e.n   = wd_mn ? n_div : 9'h0;
    e.m   = wd_mn ? m_div : 5'h0;
    e.cpu = 3'(cpu_tab[ratio_sel]);
    e.agp = 4'(agp_tab[ratio_sel]);
    e.pci = 5'(2 * agp_tab[ratio_sel]);
    e.fx  = fix_en;
    e.fa  = fix_en ? 10'(fix_tab[fix_sel]) : 10'd0;
    e.fp  = fix_en ? 10'(fix_tab[fix_sel] / 2) : 10'd0;
    e.pd  = m_done && !mf_pin;
    if (cap) begin
      m_lat  = fs_strap;
      m_cur  = cur_strap;
      m_done = 1'b1;
    end
    m_pg  = pwr_good;
    e.lfs = m_lat;
    e.lcur = m_cur;
    e.dn  = m_done;
    exp_q.push_back(e);
    tag_q.push_back(tag);
    @(negedge clk);
  endtask

  // monitor: compares after each edge that has a prediction queued
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (exp_q.size() > 0) check(tag_q.pop_front(), sample_dut(), exp_q.pop_front());
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired before the end of the run");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: everything zero while reset is held
    check("R1 reset state", sample_dut(), '0);
    rst_n = 1'b1;
    step("R1 after reset");
    fs_strap = 5'h14; mf_pin = 1'b0;
    step("R1 no capture before power-good");
    step("R3 no power-down before capture");
    mf_pin = 1'b1; fs_strap = 5'h0B;
    pwr_good = 1'b1;
    step("R2 capture on first rise");
    step("R4 hardware code after capture");
    fs_strap = 5'h1E; cur_strap = 1'b0;
    step("R2 strap change ignored");
    pwr_good = 1'b0;
    step("R2 power-good low");
    pwr_good = 1'b1;
    step("R2 second rise ignored");
    step("R2 hold");
    mf_pin = 1'b0;
    step("R3 power-down request");
    step("R3 power-down held");
    mf_pin = 1'b1;
    step("R3 power-down released");
    sw_sel_en = 1'b1; sw_code = 5'h15;
    step("R4 software code");
    sw_code = 5'h1F;
    step("R4 software code max");
    sw_sel_en = 1'b0;
    step("R4 back to hardware code");
    mn_en = 1'b1; n_div = 9'h1A5; m_div = 5'h13;
    step("R5 m/n mode");
    n_div = 9'h1FF; m_div = 5'h1F;
    step("R5 m/n max values");
    sw_sel_en = 1'b1; sw_code = 5'h09; wdt_expired = 1'b1;
    step("R6 override to hardware code");
    safe_en = 1'b1; safe_code = 5'h07;
    step("R6 override to safe code");
    step("R6 override held");
    wdt_expired = 1'b0;
    step("R6 override removed");
    mn_en = 1'b0; sw_sel_en = 1'b0; safe_en = 1'b0;
    step("R5 m/n off");
    for (int i = 0; i < 8; i++) begin
      ratio_sel = 3'(i);
      step($sformatf("R7 ratio select %0d", i));
    end
    fix_en = 1'b1;
    for (int j = 0; j < 4; j++) begin
      fix_sel = 2'(j);
      step($sformatf("R8 fixed select %0d", j));
    end
    fix_en = 1'b0;
    step("R8 fixed mode off");
    step("R8 settle");
    repeat (2) @(negedge clk);
    finish_run();
  end

endmodule